// File: doc/BRIEF.md
# Timing-Card Mode Control FSM

This block sequences the operating state of a line-card timing loop. After reset it keeps the clock and frame outputs disabled for a fixed number of millisecond ticks. It then rides in holdover until the selected reference is healthy. On the way to locked operation it passes through a one-cycle phase-offset capture state. In that state the measured phase difference between the feedback and the chosen reference is latched as the offset of a virtual reference. The output phase is therefore kept across reference switches and holdover recoveries. A mode select forces free-running operation at any time outside reset.

The block also owns the lock indicator. Lock is earned only after the phase error has stayed inside its window for a qualification period of ticks while locked operation is active. Lock survives a short holdover, but it drops once a holdover outlasts a fixed hold time, and it drops at once on free-run. An active-low clear input zeroes the held offset, so the outputs realign with the input reference. The phase detector, loop filter and oscillator are outside the block.

Top module: `tcard_mode_ctrl`

## Requirements
- R1: While `rstN` is low, and after its release until `RESET_MS` (default 3) `tick` pulses have been seen, the state output is 0 (reset), `outEn`, `lock` and `heldOffset` are 0. The tick that completes the count moves the state to 1 (holdover), or to 4 (free-run) if the synchronized mode select is 1.
- R2: Outside reset, `modeSel` high puts the state at 4 (free-run) on the third rising clock edge after the pin changes (two synchronizer flops plus the state register). In free-run, `refDis`, `refSelPin` and `phaseOk` have no effect. When `modeSel` returns low, the state goes to 1 on the third edge.
- R3: From state 3 (normal), a high `refDis` sends the state to 1 on the next edge. A toggle of `refSelPin` sends it to 1 on the fourth edge after the pin changes. A selection change seen in any state stays pending until holdover hands over to capture.
- R4: From state 1 with `refDis` low, the state goes to 2 (capture) on the next edge, and `captureStb` is high exactly while the state is 2. Capture lasts one cycle. It is followed by state 3, or by state 1 if `refDis` is high or a selection change is pending.
- R5: `heldOffset` takes the value of `phaseIn` on the edge that ends the capture state, and holds that value in every other cycle while `clrN` is high.
- R6: `clrN` low sets `heldOffset` to 0 on the next edge, with priority over a capture.
- R7: When lock is high and the state enters 1, `lock` stays high for `LOCK_HOLD_MS` (default 100) ticks in holdover and falls on the last of them. A holdover left earlier keeps it high. `lock` falls on the same edge that the state becomes 4.
- R8: In state 3, `lock` rises on the `LOCK_QUAL_MS`-th (default 1000) consecutive tick with `phaseOk` high. A cycle with `phaseOk` low clears both `lock` and the qualification count.
- R9: `holdCmd` is high exactly while the state is 1, and `outEn` is high in every state except 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle pulse per millisecond |
| modeSel | input | 1 | 1 selects free-run, 0 selects normal operation with automatic holdover (asynchronous) |
| refSelPin | input | 1 | Reference select (asynchronous); any change triggers a re-capture |
| refDis | input | 1 | Selected reference is disrupted |
| phaseOk | input | 1 | Phase error lies inside the lock window |
| clrN | input | 1 | Active-low clear of the held phase offset |
| phaseIn | input | PHASE_W | Measured feedback-to-reference phase difference |
| stateOut | output | 3 | State: 0 reset, 1 holdover, 2 capture, 3 normal, 4 free-run |
| outEn | output | 1 | Clock and frame output enable (low means tri-state) |
| holdCmd | output | 1 | Holdover command to the oscillator |
| captureStb | output | 1 | Strobe for the virtual reference offset capture |
| heldOffset | output | PHASE_W | Offset applied by the virtual reference |
| lock | output | 1 | Lock indicator |

## Verification
The hardest situation to reach from the ports is the lock hold. Lock must first be qualified over a thousand in-window ticks, and only then can holdover windows on both sides of the hold time be opened by pulsing `refDis`. The stimulus qualifies lock once. It first breaks the window mid-count to prove the counter restarts. It then runs a 50-tick holdover, which must keep lock, and a 100-tick holdover, which must drop it on its final tick. A second qualification follows so that the immediate drop on free-run is seen from a locked state. Disruption during the single capture cycle is reached by lowering and raising `refDis` on consecutive cycles.

// File: rtl/tcard_pkg.sv
package tcard_pkg;

  typedef enum logic [2:0] {
    ST_RESET    = 3'd0,
    ST_HOLDOVER = 3'd1,
    ST_CAPTURE  = 3'd2,
    ST_NORMAL   = 3'd3,
    ST_FREERUN  = 3'd4
  } tcard_state_e;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic capture;     // state is capture: load offset
    logic inNormal;    // state is normal: qualify lock
    logic inHoldover;  // state is holdover: run lock hold timer
    logic lockKill;    // next state is reset or free-run
  } ctl_strobe_t;

endpackage

// File: rtl/tcard_sync.sv
module tcard_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] asyncIn,
  output logic [W-1:0] syncOut
);

  logic [W-1:0] stageQ [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rstN) stageQ[s] <= '0;
          else       stageQ[s] <= asyncIn;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rstN) stageQ[s] <= '0;
          else       stageQ[s] <= stageQ[s-1];
        end
      end
    end
  endgenerate

  assign syncOut = stageQ[STAGES-1];

endmodule

// File: rtl/tcard_ctrl.sv
module tcard_ctrl
  import tcard_pkg::*;
#(
  parameter int RESET_MS = 3
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         tick,
  input  logic         modeSync,
  input  logic         selSync,
  input  logic         refDis,
  output tcard_state_e stateQ,
  output ctl_strobe_t  ctl
);

  localparam int RCW = (RESET_MS > 1) ? $clog2(RESET_MS) : 1;
  localparam logic [RCW-1:0] RST_LAST = RCW'(RESET_MS - 1);

  tcard_state_e   nextState;
  logic [RCW-1:0] rstCnt;
  logic           selPrev;
  logic           selChg;
  logic           chgPend;
  logic           takeCapture;

  // reset dwell counter
  always_ff @(posedge clk) begin
    if (!rstN)                    rstCnt <= '0;
    else if (stateQ != ST_RESET)  rstCnt <= '0;
    else if (tick)                rstCnt <= rstCnt + 1'b1;
  end

  // next-state logic
  always_comb begin
    nextState = stateQ;
    if (stateQ == ST_RESET) begin
      if (tick && rstCnt == RST_LAST)
        nextState = modeSync ? ST_FREERUN : ST_HOLDOVER;
    end else if (modeSync) begin
      nextState = ST_FREERUN;
    end else begin
      unique case (stateQ)
        ST_FREERUN:  nextState = ST_HOLDOVER;
        ST_HOLDOVER: if (!refDis) nextState = ST_CAPTURE;
        ST_CAPTURE:  nextState = (refDis || chgPend) ? ST_HOLDOVER : ST_NORMAL;
        ST_NORMAL:   if (refDis || chgPend) nextState = ST_HOLDOVER;
        default:     nextState = ST_HOLDOVER;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_RESET;
    else       stateQ <= nextState;
  end

  // reference-select change detection and pending latch
  assign selChg      = selSync ^ selPrev;
  assign takeCapture = (stateQ == ST_HOLDOVER) && (nextState == ST_CAPTURE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selPrev <= 1'b0;
      chgPend <= 1'b0;
    end else begin
      selPrev <= selSync;
      if (selChg)           chgPend <= 1'b1;
      else if (takeCapture) chgPend <= 1'b0;
    end
  end

  // strobes to the datapath
  always_comb begin
    ctl.capture    = (stateQ == ST_CAPTURE);
    ctl.inNormal   = (stateQ == ST_NORMAL);
    ctl.inHoldover = (stateQ == ST_HOLDOVER);
    ctl.lockKill   = (nextState == ST_FREERUN) || (nextState == ST_RESET);
  end

  AST_RESET_EXIT: assert property (@(posedge clk) disable iff (!rstN)
    stateQ == ST_RESET |=> stateQ inside {ST_RESET, ST_HOLDOVER, ST_FREERUN}); // R1
  AST_FREERUN_FORCE: assert property (@(posedge clk) disable iff (!rstN)
    (modeSync && stateQ != ST_RESET) |=> stateQ == ST_FREERUN); // R2
  AST_NORMAL_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_NORMAL && !modeSync && (refDis || chgPend)) |=> stateQ == ST_HOLDOVER); // R3
  AST_CHANGE_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    selChg |=> chgPend); // R3
  AST_CAPTURE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    stateQ == ST_CAPTURE |=> stateQ != ST_CAPTURE); // R4
  AST_CAPTURE_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stateQ == ST_CAPTURE) |-> $past(stateQ) == ST_HOLDOVER); // R4

endmodule

// File: rtl/tcard_dpath.sv
module tcard_dpath
  import tcard_pkg::*;
#(
  parameter int PHASE_W      = 16,
  parameter int LOCK_QUAL_MS = 1000,
  parameter int LOCK_HOLD_MS = 100
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               tick,
  input  logic               phaseOk,
  input  logic               clrN,
  input  logic [PHASE_W-1:0] phaseIn,
  input  ctl_strobe_t        ctl,
  output logic [PHASE_W-1:0] heldOffset,
  output logic               lock
);

  localparam int QCW = $clog2(LOCK_QUAL_MS + 1);
  localparam int HCW = $clog2(LOCK_HOLD_MS + 1);
  localparam logic [QCW-1:0] QUAL_LAST = QCW'(LOCK_QUAL_MS - 1);
  localparam logic [QCW-1:0] QUAL_FULL = QCW'(LOCK_QUAL_MS);
  localparam logic [HCW-1:0] HOLD_LAST = HCW'(LOCK_HOLD_MS - 1);
  localparam logic [HCW-1:0] HOLD_FULL = HCW'(LOCK_HOLD_MS);

  logic [QCW-1:0] qualCnt;
  logic [HCW-1:0] holdCnt;
  logic           lockQ;

  // virtual reference offset register
  always_ff @(posedge clk) begin
    if (!rstN)            heldOffset <= '0;
    else if (!clrN)       heldOffset <= '0;
    else if (ctl.capture) heldOffset <= phaseIn;
  end

  // lock qualification and holdover hold timer
  always_ff @(posedge clk) begin
    if (!rstN || ctl.lockKill) begin
      lockQ   <= 1'b0;
      qualCnt <= '0;
      holdCnt <= '0;
    end else if (ctl.inHoldover) begin
      if (tick && holdCnt != HOLD_FULL) begin
        holdCnt <= holdCnt + 1'b1;
        if (holdCnt == HOLD_LAST) begin
          lockQ   <= 1'b0;
          qualCnt <= '0;
        end
      end
    end else begin
      holdCnt <= '0;
      if (ctl.inNormal) begin
        if (!phaseOk) begin
          lockQ   <= 1'b0;
          qualCnt <= '0;
        end else if (tick && !lockQ) begin
          if (qualCnt == QUAL_LAST) begin
            lockQ   <= 1'b1;
            qualCnt <= QUAL_FULL;
          end else begin
            qualCnt <= qualCnt + 1'b1;
          end
        end
      end
    end
  end

  assign lock = lockQ;

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !clrN |=> heldOffset == '0); // R6
  AST_OFFSET_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (clrN && !ctl.capture) |=> $stable(heldOffset)); // R5
  AST_LOCK_KILL: assert property (@(posedge clk) disable iff (!rstN)
    ctl.lockKill |=> !lock); // R7
  AST_LOCK_RISE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lock) |-> $past(ctl.inNormal && phaseOk)); // R8
  AST_WINDOW_LOSS: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.inNormal && !phaseOk) |=> !lock); // R8

endmodule

// File: rtl/tcard_mode_ctrl.sv
module tcard_mode_ctrl
  import tcard_pkg::*;
#(
  parameter int PHASE_W      = 16,
  parameter int RESET_MS     = 3,
  parameter int LOCK_QUAL_MS = 1000,
  parameter int LOCK_HOLD_MS = 100,
  parameter int SYNC_STAGES  = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               tick,
  input  logic               modeSel,
  input  logic               refSelPin,
  input  logic               refDis,
  input  logic               phaseOk,
  input  logic               clrN,
  input  logic [PHASE_W-1:0] phaseIn,
  output logic [2:0]         stateOut,
  output logic               outEn,
  output logic               holdCmd,
  output logic               captureStb,
  output logic [PHASE_W-1:0] heldOffset,
  output logic               lock
);

  logic [1:0]   pinSync;
  tcard_state_e stateQ;
  ctl_strobe_t  ctl;

  tcard_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn ({modeSel, refSelPin}),
    .syncOut (pinSync)
  );

  tcard_ctrl #(.RESET_MS(RESET_MS)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .tick     (tick),
    .modeSync (pinSync[1]),
    .selSync  (pinSync[0]),
    .refDis   (refDis),
    .stateQ   (stateQ),
    .ctl      (ctl)
  );

  tcard_dpath #(
    .PHASE_W      (PHASE_W),
    .LOCK_QUAL_MS (LOCK_QUAL_MS),
    .LOCK_HOLD_MS (LOCK_HOLD_MS)
  ) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .tick       (tick),
    .phaseOk    (phaseOk),
    .clrN       (clrN),
    .phaseIn    (phaseIn),
    .ctl        (ctl),
    .heldOffset (heldOffset),
    .lock       (lock)
  );

  assign stateOut   = stateQ;
  assign outEn      = (stateQ != ST_RESET);
  assign holdCmd    = ctl.inHoldover;
  assign captureStb = ctl.capture;

  AST_DARK_NO_LOCK: assert property (@(posedge clk) disable iff (!rstN)
    !outEn |-> !lock); // R1
  AST_HOLD_CMD: assert property (@(posedge clk) disable iff (!rstN)
    holdCmd |-> (outEn && !captureStb)); // R9

endmodule

// File: tb/tcard_mode_ctrl_test.sv
module tcard_mode_ctrl_test;

  localparam int PW = 16;
  localparam int S_RST = 0, S_HOLD = 1, S_CAP = 2, S_NORM = 3, S_FREE = 4;

  // {phase, clrN, expected held offset}
  localparam logic [2*PW:0] VEC [6] = '{
    {16'h00A5, 1'b1, 16'h00A5},
    {16'hFFFF, 1'b1, 16'hFFFF},
    {16'h8000, 1'b0, 16'h0000},
    {16'h7FFF, 1'b1, 16'h7FFF},
    {16'h0001, 1'b0, 16'h0000},
    {16'h0000, 1'b1, 16'h0000}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick = 1'b0;
  logic modeSel = 1'b0;
  logic refSelPin = 1'b0;
  logic refDis = 1'b1;
  logic phaseOk = 1'b0;
  logic clrN = 1'b1;
  logic [PW-1:0] phaseIn = '0;
  logic [2:0] stateOut;
  logic outEn, holdCmd, captureStb, lock;
  logic [PW-1:0] heldOffset;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tcard_mode_ctrl uut (
    .clk(clk), .rstN(rstN), .tick(tick), .modeSel(modeSel), .refSelPin(refSelPin),
    .refDis(refDis), .phaseOk(phaseOk), .clrN(clrN), .phaseIn(phaseIn),
    .stateOut(stateOut), .outEn(outEn), .holdCmd(holdCmd), .captureStb(captureStb),
    .heldOffset(heldOffset), .lock(lock)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finishRun();
  end

  initial begin
    // reset state
    step(4);
    chk("R1 state in reset", stateOut, S_RST);
    chk("R1 outEn in reset", outEn, 0);
    chk("R1 lock in reset", lock, 0);
    chk("R1 offset in reset", heldOffset, 0);
    rstN = 1'b1;
    step(5);
    chk("R1 no ticks keeps reset", stateOut, S_RST);
    tick = 1'b1;
    step(2);
    chk("R1 reset before third tick", stateOut, S_RST);
    chk("R1 outEn dark", outEn, 0);
    step(1);
    chk("R1 holdover after third tick", stateOut, S_HOLD);
    chk("R9 outEn after reset", outEn, 1);
    chk("R9 holdCmd in holdover", holdCmd, 1);

    // first capture pass
    refDis = 1'b0;
    phaseIn = 16'h1234;
    step(1);
    chk("R4 capture state", stateOut, S_CAP);
    chk("R4 capture strobe", captureStb, 1);
    chk("R9 holdCmd low in capture", holdCmd, 0);
    chk("R5 offset before capture edge", heldOffset, 0);
    step(1);
    chk("R4 normal after capture", stateOut, S_NORM);
    chk("R4 strobe low in normal", captureStb, 0);
    chk("R5 captured offset", heldOffset, 16'h1234);

    // lock qualification with a window break
    phaseOk = 1'b1;
    step(500);
    chk("R8 no lock mid count", lock, 0);
    phaseOk = 1'b0;
    step(1);
    phaseOk = 1'b1;
    step(999);
    chk("R8 no lock one tick early", lock, 0);
    step(1);
    chk("R8 lock after qualification", lock, 1);

    // short holdover keeps lock
    refDis = 1'b1;
    step(1);
    chk("R3 disruption to holdover", stateOut, S_HOLD);
    step(50);
    chk("R7 lock held in short holdover", lock, 1);
    refDis = 1'b0;
    step(2);
    chk("R4 back to normal", stateOut, S_NORM);
    chk("R7 lock kept after short holdover", lock, 1);

    // offset capture vectors
    for (int i = 0; i < 6; i++) begin
      logic [PW-1:0] vPh, vExp;
      logic vClr;
      {vPh, vClr, vExp} = VEC[i];
      phaseIn = vPh;
      clrN = vClr;
      refDis = 1'b1;
      step(1);
      refDis = 1'b0;
      step(1);
      chk("R4 vector capture", stateOut, S_CAP);
      step(1);
      chk("R4 vector normal", stateOut, S_NORM);
      chk(vClr ? "R5 vector offset" : "R6 clear beats capture", heldOffset, vExp);
      clrN = 1'b1;
      phaseIn = ~vPh;
      step(3);
      chk("R5 offset stable outside capture", heldOffset, vExp);
    end
    chk("R7 lock through vector holdovers", lock, 1);

    // direct clear
    phaseIn = 16'h5A5A;
    refDis = 1'b1;
    step(1);
    refDis = 1'b0;
    step(2);
    chk("R5 offset loaded", heldOffset, 16'h5A5A);
    clrN = 1'b0;
    step(1);
    chk("R6 clear zeroes offset", heldOffset, 0);
    clrN = 1'b1;
    step(2);
    chk("R6 offset stays zero", heldOffset, 0);

    // long holdover drops lock
    refDis = 1'b1;
    step(1);
    chk("R3 holdover again", stateOut, S_HOLD);
    step(99);
    chk("R7 lock held on tick 99", lock, 1);
    step(1);
    chk("R7 lock dropped on tick 100", lock, 0);

    // disruption during capture
    refDis = 1'b0;
    step(1);
    chk("R4 capture entered", stateOut, S_CAP);
    refDis = 1'b1;
    step(1);
    chk("R4 disrupted capture returns to holdover", stateOut, S_HOLD);
    refDis = 1'b0;
    step(2);
    chk("R4 normal after retry", stateOut, S_NORM);

    // reference select change
    phaseIn = 16'h0C0C;
    refSelPin = 1'b1;
    step(3);
    chk("R3 still normal before sync", stateOut, S_NORM);
    step(1);
    chk("R3 select change to holdover", stateOut, S_HOLD);
    step(1);
    chk("R4 capture after select change", stateOut, S_CAP);
    step(1);
    chk("R4 normal after select change", stateOut, S_NORM);
    chk("R5 offset for new reference", heldOffset, 16'h0C0C);
    step(2);
    chk("R3 pending cleared", stateOut, S_NORM);

    // requalify then free-run
    step(1000);
    chk("R8 relock", lock, 1);
    modeSel = 1'b1;
    step(2);
    chk("R2 normal before sync", stateOut, S_NORM);
    chk("R7 lock before free-run", lock, 1);
    step(1);
    chk("R2 free-run entered", stateOut, S_FREE);
    chk("R7 lock drops on free-run", lock, 0);
    refDis = 1'b1;
    refSelPin = 1'b0;
    phaseOk = 1'b0;
    step(4);
    refDis = 1'b0;
    phaseOk = 1'b1;
    step(6);
    chk("R2 free-run ignores inputs", stateOut, S_FREE);
    chk("R2 no lock in free-run", lock, 0);
    modeSel = 1'b0;
    step(2);
    chk("R2 free-run before sync", stateOut, S_FREE);
    step(1);
    chk("R2 back to holdover", stateOut, S_HOLD);
    step(2);
    chk("R4 normal after free-run", stateOut, S_NORM);

    // reset in the middle of operation
    rstN = 1'b0;
    step(1);
    chk("R1 mid-run reset state", stateOut, S_RST);
    chk("R1 mid-run reset outEn", outEn, 0);
    chk("R1 mid-run reset offset", heldOffset, 0);
    rstN = 1'b1;
    step(3);
    chk("R1 leaves reset after ticks", stateOut, S_HOLD);

    finishRun();
  end

endmodule